// File: doc/BRIEF.md
# Reset Strap Capture Unit

This block samples configuration strap pins into registers that the rest of the chip reads. Each strap latches on the event that suits it. The boot-mode field and the security-mode bit load only after a power-up style reset. The flash configuration field and the self-test request load each time reset is released. The socket-disable bit tracks its pin while reset is held. The socket identifier loads whenever power-good changes level.

All pins cross into the reference clock domain through two-flop synchronizers. Reset is applied asynchronously and released through two flops. A reset counts as cold when power-good rises while reset is held. Any other reset counts as warm. The block also measures how stable the reset-latched straps are around each reset, in reference clocks. It raises a sticky flag if a strap moves inside a setup or hold window.

Top module: `strap_capture`

## Requirements
- R1: The boot-mode and security-mode outputs load the synchronized pin values at reset release only if that reset was cold. After a warm reset they keep their previous values.
- R2: The flash configuration and self-test request outputs load the synchronized pins at every reset release. Between releases they hold steady whatever the pins do.
- R3: While reset is held, the socket-disable output follows its synchronized pin. After release it keeps the last value taken during reset.
- R4: The socket identifier output loads the synchronized identifier pins on each change of synchronized power-good. It is unaffected by resets that leave power-good steady.
- R5: The cold flag reads 1 after the release of a reset during which power-good rose. It reads 0 after any other reset.
- R6: A change on any reset-latched strap (boot-mode, security-mode, flash configuration, socket-disable, self-test) within HOLD_CLKS (default 108) clocks after reset release sets the timing-error flag. A change later than that does not.
- R7: A reset-latched strap change seen within SETUP_CLKS (default 2) clocks on either side of a detected reset assertion, or of a power-good rise during reset, sets the timing-error flag.
- R8: The timing-error flag is sticky through warm resets. It clears only when power-good rises during reset or while power-good is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Power-good level |
| boot_mode_i | input | BOOT_W | Boot-mode strap pins |
| sec_mode_i | input | 1 | Security-mode strap pin |
| flash_cfg_i | input | FLASH_W | Flash configuration strap pins |
| skt_dis_n_i | input | 1 | Socket-disable strap, active low |
| bist_req_i | input | 1 | Self-test request strap |
| skt_id_i | input | SKT_W | Socket identifier pins |
| boot_mode_o | output | BOOT_W | Latched boot-mode |
| sec_mode_o | output | 1 | Latched security-mode |
| flash_cfg_o | output | FLASH_W | Latched flash configuration |
| skt_dis_n_o | output | 1 | Socket-disable value |
| bist_req_o | output | 1 | Latched self-test request |
| skt_id_o | output | SKT_W | Latched socket identifier |
| cold_last_o | output | 1 | 1 when the last reset was cold |
| timing_err_o | output | 1 | Sticky strap setup/hold violation |

## Verification
Some properties are checked on every cycle. These are: stability of the flash and self-test outputs between releases, boot-mode retention across warm resets, socket-disable tracking during reset, identifier retention while power-good is steady, and stickiness of the error flag. Only the bench's scenarios can show the rest. That covers a strap change landing inside or beyond the hold window, a change coinciding with reset assertion, cold and warm classification after complete power sequences, and the mix of random strap values across alternating reset kinds.

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int BOOT_W     = 2,
  parameter int FLASH_W    = 3,
  parameter int SKT_W      = 3,
  parameter int SETUP_CLKS = 2,
  parameter int HOLD_CLKS  = 108
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic [BOOT_W-1:0]  boot_mode_i,
  input  logic               sec_mode_i,
  input  logic [FLASH_W-1:0] flash_cfg_i,
  input  logic               skt_dis_n_i,
  input  logic               bist_req_i,
  input  logic [SKT_W-1:0]   skt_id_i,
  output logic [BOOT_W-1:0]  boot_mode_o,
  output logic               sec_mode_o,
  output logic [FLASH_W-1:0] flash_cfg_o,
  output logic               skt_dis_n_o,
  output logic               bist_req_o,
  output logic [SKT_W-1:0]   skt_id_o,
  output logic               cold_last_o,
  output logic               timing_err_o
);
  localparam int ST_W = BOOT_W + FLASH_W + 3;
  localparam int HC_W = $clog2(HOLD_CLKS + 1);
  localparam int SC_W = $clog2(SETUP_CLKS + 1);
  localparam int SEC_B = FLASH_W + 2;

  logic [1:0]      rst_sync;
  logic            rs_q;
  logic [1:0]      pg_sync;
  logic            pg_q;
  logic [ST_W-1:0] st_m, st_s, st_q;
  logic [SKT_W-1:0] id_m, id_s;
  logic [SC_W-1:0] stab_cnt, win_cnt;
  logic [HC_W-1:0] hold_cnt;
  logic            cold_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};

  wire rs = ~rst_sync[1];
  wire pg_s = pg_sync[1];

  always_ff @(posedge clk) begin
    rs_q    <= rs;
    pg_sync <= {pg_sync[0], pwr_good};
    pg_q    <= pg_s;
    st_m    <= {boot_mode_i, sec_mode_i, flash_cfg_i, skt_dis_n_i, bist_req_i};
    st_s    <= st_m;
    st_q    <= st_s;
    id_m    <= skt_id_i;
    id_s    <= id_m;
  end

  wire rst_on   = rs & ~rs_q;
  wire rst_off  = ~rs & rs_q;
  wire pg_tog   = pg_s ^ pg_q;
  wire cold_evt = pg_s & ~pg_q & rs;
  wire chg      = st_s != st_q;
  wire edge_evt = rst_on | cold_evt;

  wire setup_bad = (edge_evt && stab_cnt < SC_W'(SETUP_CLKS)) || (chg && win_cnt != '0);
  wire hold_bad  = chg && hold_cnt != '0;

  always_ff @(posedge clk)
    if (chg)                            stab_cnt <= '0;
    else if (stab_cnt != SC_W'(SETUP_CLKS)) stab_cnt <= stab_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!pg_s) begin
      win_cnt      <= '0;
      hold_cnt     <= '0;
      timing_err_o <= 1'b0;
      cold_pend    <= 1'b0;
    end else begin
      if (edge_evt)            win_cnt <= SC_W'(SETUP_CLKS);
      else if (win_cnt != '0)  win_cnt <= win_cnt - 1'b1;
      if (rst_off)             hold_cnt <= HC_W'(HOLD_CLKS);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (setup_bad || hold_bad) timing_err_o <= 1'b1;
      else if (cold_evt)         timing_err_o <= 1'b0;
      if (cold_evt)      cold_pend <= 1'b1;
      else if (rst_off)  cold_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_off) begin
      flash_cfg_o <= st_s[FLASH_W+1:2];
      bist_req_o  <= st_s[0];
      cold_last_o <= cold_pend;
      if (cold_pend) begin
        boot_mode_o <= st_s[ST_W-1 -: BOOT_W];
        sec_mode_o  <= st_s[SEC_B];
      end
    end
    if (rs)     skt_dis_n_o <= st_s[1];
    if (pg_tog) skt_id_o    <= id_s;
  end

  p_keep_flash_r2: assert property (@(posedge clk) disable iff (!pg_s)
    (!rs && !rs_q) |=> ($stable(flash_cfg_o) && $stable(bist_req_o)));
  p_warm_keeps_boot_r1: assert property (@(posedge clk) disable iff (!pg_s)
    (rst_off && !cold_pend) |=> ($stable(boot_mode_o) && $stable(sec_mode_o)));
  p_dis_follows_r3: assert property (@(posedge clk) disable iff (!pg_s)
    rs |=> (skt_dis_n_o == $past(st_s[1])));
  p_dis_frozen_r3: assert property (@(posedge clk) disable iff (!pg_s)
    !rs |=> $stable(skt_dis_n_o));
  p_id_hold_r4: assert property (@(posedge clk) disable iff (!pg_s)
    (pg_s == pg_q) |=> $stable(skt_id_o));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!pg_s)
    (timing_err_o && !cold_evt) |=> timing_err_o);
  p_hold_flag_r6: assert property (@(posedge clk) disable iff (!pg_s)
    hold_bad |=> timing_err_o);
endmodule

// File: tb/sim_strap_capture.sv
module sim_strap_capture;
  logic clk = 0, rst_n = 0, pwr_good = 0;
  logic [1:0] boot_i = 0; logic sec_i = 0; logic [2:0] flash_i = 0;
  logic dis_i = 1, bist_i = 0; logic [2:0] id_i = 0;
  logic [1:0] boot_o; logic sec_o; logic [2:0] flash_o;
  logic dis_o, bist_o, cold_o, err_o; logic [2:0] id_o;
  int checks = 0, fails = 0;
  logic [1:0] e_boot; logic e_sec; logic [2:0] e_flash; logic e_dis, e_bist, e_cold, e_err;
  logic [2:0] e_id;

  always #5 clk = ~clk;

  strap_capture u0 (.clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .boot_mode_i(boot_i), .sec_mode_i(sec_i), .flash_cfg_i(flash_i),
    .skt_dis_n_i(dis_i), .bist_req_i(bist_i), .skt_id_i(id_i),
    .boot_mode_o(boot_o), .sec_mode_o(sec_o), .flash_cfg_o(flash_o),
    .skt_dis_n_o(dis_o), .bist_req_o(bist_o), .skt_id_o(id_o),
    .cold_last_o(cold_o), .timing_err_o(err_o));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R1 boot"}, boot_o, e_boot);
    chk({tag, " R1 sec"}, sec_o, e_sec);
    chk({tag, " R2 flash"}, flash_o, e_flash);
    chk({tag, " R2 bist"}, bist_o, e_bist);
    chk({tag, " R3 dis"}, dis_o, e_dis);
    chk({tag, " R4 id"}, id_o, e_id);
    chk({tag, " R5 cold"}, cold_o, e_cold);
    chk({tag, " R8 err"}, err_o, e_err);
  endtask

  function automatic logic [7:0] pins();
    return {boot_i, sec_i, flash_i, dis_i, bist_i};
  endfunction

  task automatic take_release(input bit cold);
    if (cold) begin e_boot = boot_i; e_sec = sec_i; end
    e_flash = flash_i; e_bist = bist_i; e_dis = dis_i; e_cold = cold;
  endtask

  task automatic do_cold();
    pwr_good = 0; rst_n = 0; tick(6);
    pwr_good = 1; tick(6);
    e_id = id_i; e_err = 0;
    rst_n = 1; tick(8);
    take_release(1);
  endtask

  task automatic do_warm();
    rst_n = 0; tick(6);
    rst_n = 1; tick(8);
    take_release(0);
  endtask

  task automatic set_pins(input logic [10:0] v);
    {boot_i, sec_i, flash_i, dis_i, bist_i, id_i} = v;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    tick(4);
    set_pins(11'b10_1_101_0_1_011);
    tick(10);
    do_cold();
    check_all("cold reset state");

    tick(120);
    set_pins(11'b01_0_010_1_0_110);
    tick(10);
    do_warm();
    check_all("warm keeps cold straps");

    tick(120);
    rst_n = 0; tick(6);
    dis_i = 0; tick(5);
    chk("R3 follows during reset", dis_o, 0);
    rst_n = 1; tick(8); take_release(0);
    tick(120);
    dis_i = 1; flash_i = 3'b111; tick(6);
    chk("R3 frozen after release", dis_o, 0);
    chk("R2 flash held between resets", flash_o, e_flash);
    chk("R6 late change no error", err_o, 0);

    tick(20);
    do_warm();
    tick(40);
    flash_i = 3'b001; tick(6);
    chk("R6 change in hold window", err_o, 1);
    e_err = 1;
    tick(120);
    do_warm();
    check_all("R8 sticky over warm");
    tick(120);
    do_cold();
    check_all("R8 cleared by cold");

    tick(120);
    boot_i = ~boot_i; rst_n = 0; tick(6);
    rst_n = 1; tick(8); take_release(0);
    chk("R7 change at reset assertion", err_o, 1);
    e_err = 1;
    check_all("R7 warm after setup miss");
    tick(120);
    do_cold();
    check_all("R5 cold after setup miss");

    tick(120);
    id_i = ~id_i; pwr_good = 0; tick(6);
    chk("R4 id on power-good fall", id_o, id_i);

    for (int i = 0; i < 24; i++) begin
      tick(120);
      set_pins(11'($urandom));
      tick(10);
      if ($urandom_range(0, 2) == 0 || !pwr_good) do_cold();
      else do_warm();
      check_all($sformatf("random %0d", i));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule